// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is the 32-bit integer execute unit of a small in-order core. It is purely combinational. It takes two operands and a 4-bit operation code, and it presents the result in the same cycle. Operand A always comes from a register. Operand B is either a register value or an immediate that the decode stage has already sign-extended. For immediate shifts, operand B carries the shift-amount field from the instruction.

The unit covers wrapping add and subtract, the three bitwise operations, logical left shift, logical and arithmetic right shift, and signed and unsigned set-less-than. A single adder serves both arithmetic and comparison. A single barrel shifter serves all three shift kinds. The unit has no flags output, no handshake and no internal state. Decode is responsible for never issuing subtract with an immediate operand.

Top module: `rv_int_alu`

## Requirements
- R1: With op code 0 (add), result equals (opa + opb) modulo 2^32, and there is no overflow indication.
- R2: With op code 1 (subtract), result equals (opa - opb) modulo 2^32.
- R3: With op code 2 (shift left), result equals opa shifted left by opb[4:0], and zeros fill the low bits.
- R4: With op code 3 (signed less-than), result is 1 when opa is below opb as two's-complement numbers and 0 otherwise. Bits 31..1 are always zero.
- R5: With op code 4 (unsigned less-than), result is 1 when opa is below opb as unsigned numbers and 0 otherwise. Bits 31..1 are always zero.
- R6: Op code 5 gives opa XOR opb, op code 8 gives opa OR opb, and op code 9 gives opa AND opb.
- R7: With op code 6 (logical right shift), result equals opa shifted right by opb[4:0], and zeros fill the vacated upper bits.
- R8: With op code 7 (arithmetic right shift), result equals opa shifted right by opb[4:0], and copies of opa[31] fill the vacated upper bits.
- R9: Op codes 10 to 15 give a result of zero for any operands.
- R10: For all shifts, opb[31:5] is ignored. Only opb[4:0] sets the amount, so the amount ranges from 0 to 31.
- R11: The result is a combinational function of the current inputs, so the settled output is valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| opa | input | 32 | Operand A, a register value |
| opb | input | 32 | Operand B: a register value, a sign-extended immediate, or a shift amount |
| result | output | 32 | Operation result |

## Verification
The bench drives a grid of edge operands through every op code. The edge operands are zero, one, all-ones, the most negative and most positive values, and values just beside them. The grid catches three kinds of error:
- A comparison that only tests the difference's sign bit answers wrongly when opa and opb have opposite signs and the subtraction overflows.
- An unsigned compare taken from the wrong carry polarity inverts on equal operands.
- An arithmetic shift that fills with zeros fails as soon as opa is negative.

The bench sweeps every shift amount from 0 to 31 and sets garbage in opb[31:5]. A shifter that reads too many bits of opb, or that mishandles amount 0 or 31, shows up here. The bench also checks that unused codes produce zero, and then runs a long pseudo-random pass against a reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SHL  = 4'd2,
    OP_LTS  = 4'd3,
    OP_LTU  = 4'd4,
    OP_XOR  = 4'd5,
    OP_SHRL = 4'd6,
    OP_SHRA = 4'd7,
    OP_OR   = 4'd8,
    OP_AND  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W:0] wide;

  assign wide = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
  assign sum  = wide[W-1:0];
  // no borrow out of a - b means a >= b
  assign lt_u = ~wide[W];
  // differing signs decide directly; otherwise the difference cannot overflow
  assign lt_s = (a[W-1] ^ b[W-1]) ? a[W-1] : wide[W-1];

  always_comb begin
    if (sub) begin
      // R5
      ltu_order_chk: assert (lt_u == (a < b));
      // R4
      lts_order_chk: assert (lt_s == ($signed(a) < $signed(b)));
    end
  end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [W-1:0] rev_in;
  logic [W-1:0] stage [0:SW];
  logic [W-1:0] rev_out;
  logic         fill;

  // left shifts reuse the right shifter on a bit-reversed operand
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = left ? din[W-1-i] : din[i];
    assign rev_out[i] = left ? stage[SW][W-1-i] : stage[SW][i];
  end

  assign fill     = arith & ~left & din[W-1];
  assign stage[0] = rev_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
  end

  assign dout = rev_out;

  always_comb begin
    if (amt == '0) begin
      // R10
      zero_shift_chk: assert (dout == din);
    end
    if (!left && arith) begin
      // R8
      sign_keep_chk: assert (dout[W-1] == din[W-1]);
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] x_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] and_o
);
  assign x_o   = a ^ b;
  assign or_o  = a | b;
  assign and_o = a & b;

  always_comb begin
    // R6
    bit_identity_chk: assert (or_o == (x_o | and_o));
  end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result
);
  import alu_pkg::*;

  logic         sub_en;
  logic [W-1:0] sum;
  logic         lt_s, lt_u;
  logic [W-1:0] sh_out;
  logic         sh_left, sh_arith;
  logic [W-1:0] x_v, or_v, and_v;

  assign sub_en   = (op_sel == OP_SUB) || (op_sel == OP_LTS) || (op_sel == OP_LTU);
  assign sh_left  = (op_sel == OP_SHL);
  assign sh_arith = (op_sel == OP_SHRA);

  alu_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(sub_en), .sum(sum), .lt_s(lt_s), .lt_u(lt_u)
  );

  alu_barrel #(.W(W)) u_barrel (
    .din(opa), .amt(opb[SW-1:0]), .left(sh_left), .arith(sh_arith), .dout(sh_out)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a(opa), .b(opb), .x_o(x_v), .or_o(or_v), .and_o(and_v)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:  result = sum;
      OP_SHL, OP_SHRL,
      OP_SHRA:         result = sh_out;
      OP_LTS:          result = {{(W-1){1'b0}}, lt_s};
      OP_LTU:          result = {{(W-1){1'b0}}, lt_u};
      OP_XOR:          result = x_v;
      OP_OR:           result = or_v;
      OP_AND:          result = and_v;
      default:         result = '0;
    endcase
  end

  always_comb begin
    if (op_sel > 4'd9) begin
      // R9
      unused_zero_chk: assert (result == '0);
    end
    if (op_sel == OP_LTS || op_sel == OP_LTU) begin
      // R4 R5
      lt_narrow_chk: assert (result[W-1:1] == '0);
    end
    if (op_sel == OP_SUB) begin
      // R2
      sub_inverse_chk: assert (result + opb == opa);
    end
  end
endmodule

// File: tb/rv_int_alu_test.sv
module rv_int_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel;
  logic [31:0] opa, opb;
  logic [31:0] result;
  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2.5 clk = ~clk;

  rv_int_alu uut (.op_sel(op_sel), .opa(opa), .opb(opb), .result(result));

  function automatic logic [31:0] corner(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;
      7: return 32'hFFFF_FFFE;
      8: return 32'h0000_001F;
      9: return 32'h0000_0020;
      10: return 32'hA5A5_5A5A;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [31:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    int sh;
    sh = int'(b % 32);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a << sh;
      4'd3: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd4: return (a < b) ? 32'd1 : 32'd0;
      4'd5: return a ^ b;
      4'd6: return a >> sh;
      4'd7: return 32'($signed(a) >>> sh);
      4'd8: return a | b;
      4'd9: return a & b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd8, 4'd9: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b, string req);
    logic [31:0] exp;
    @(posedge clk);
    #0.5;
    op_sel = op; opa = a; opb = b;
    exp = model(op, a, b);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, result, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    op_sel = 4'd0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R11 all-zero inputs settle to zero in the same cycle
    apply(4'd0, 32'd0, 32'd0, "R11");
    // R1 wrap-around
    apply(4'd0, 32'hFFFF_FFFF, 32'd1, "R1");
    // R2 borrow wrap
    apply(4'd1, 32'd0, 32'd1, "R2");
    // R4 overflowing difference with opposite signs
    apply(4'd3, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    // R5 equal operands
    apply(4'd4, 32'h1234_5678, 32'h1234_5678, "R5");
    // R8 negative fill at 31
    apply(4'd7, 32'h8000_0000, 32'd31, "R8");

    // corner grid over all codes
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(4'(op), corner(i), corner(j), tag(4'(op)));

    // every shift amount with junk in the upper bits of opb
    for (int k = 0; k < 32; k++) begin
      apply(4'd2, 32'h8765_4321, 32'(k), "R3");
      apply(4'd6, 32'h8765_4321, 32'(k), "R7");
      apply(4'd7, 32'h8765_4321, 32'(k), "R8");
      apply(4'd2, 32'hC001_D00D, 32'hFFFF_FFE0 | 32'(k), "R10");
      apply(4'd6, 32'hC001_D00D, 32'hABCD_0000 | 32'(k), "R10");
      apply(4'd7, 32'hC001_D00D, 32'h0000_0020 | 32'(k), "R10");
    end

    // pseudo-random sweep, every code
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra;
      next_rand(); ra = lfsr;
      next_rand();
      apply(4'(n % 16), ra, lfsr, tag(4'(n % 16)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule